// File: doc/BRIEF.md
# Stereo Digital Volume Stage with Soft Mute

This block scales a stream of stereo audio samples by a gain that is set separately for each channel. Each channel takes a signed 8-bit volume code in half-decibel units. The usable range runs from +24 dB at the top to -63.5 dB at the bottom, and the most negative code silences the channel completely. The block applies the gain as a mantissa for the position within a 6 dB octave combined with an arithmetic shift. It saturates the result to the sample width.

A soft mute request does not cut the signal at once. It adds an attenuation offset that rises by one half-decibel step with every accepted sample, up to 255 steps. When the request is withdrawn, the offset falls again by one step per sample. A four-state machine tracks this ramp:

- **PASS**: offset zero, no mute requested.
- **FALL**: the offset is rising.
- **HELD**: the offset is at its maximum of 255.
- **RISE**: the offset is falling.

The named transitions, all taken only on an accepted sample, are:

- **start_fade**: PASS to FALL.
- **reach_floor**: FALL or RISE to HELD, when the offset arrives at 255.
- **release**: FALL or HELD to RISE.
- **resume_fade**: RISE to FALL.
- **settle**: FALL or RISE to PASS, when the offset arrives at 0.

When an external gain controller is active (bypass input high), the programmed codes are ignored and the gain is unity. The mute offset still applies in that case.

Top module: `soft_mute_volume`

## Requirements
- R1: A volume code is a signed 8-bit count of 0.5 dB steps. Code 0 with no mute offset gives an output sample equal to the input sample.
- R2: Codes above +48 act as +48 (+24 dB). The output is saturated to the signed 16-bit range [-32768, 32767].
- R3: For an effective level e (in half-dB steps, -127 <= e <= 48), write e = 12q + r with 0 <= r < 12. The output is floor(x * M(r) * 2^q / 16384), saturated, where M(r) = round(16384 * 2^(r/12)).
- R4: Code -128 gives an output of exactly 0 while bypass is low.
- R5: The left channel uses only the left sample and left code. The right channel uses only the right sample and right code.
- R6: The codes, the mute request and the bypass input are sampled only in a cycle where in_valid is high. Their values in other cycles have no effect.
- R7: Each accepted sample with the mute request high raises the offset by 1, saturating at 255. The sample itself uses the updated offset. The effective level is the clamped code minus the offset, and a level below -127 gives an output of 0.
- R8: Each accepted sample with the mute request low lowers the offset by 1, stopping at 0. After a full release the programmed gain is restored exactly.
- R9: With bypass high, the gain code is taken as 0 for both channels, including when the code is -128. The mute offset still applies.
- R10: out_valid is high exactly two cycles after each cycle with in_valid high, and is never high otherwise.
- R11: After reset, out_valid, out_left and out_right are 0 and the mute offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| vol_left | input | 8 | Left volume code, signed half-dB |
| vol_right | input | 8 | Right volume code, signed half-dB |
| mute_req | input | 1 | Soft mute request |
| agc_bypass | input | 1 | External gain control active; forces unity gain |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 16 | Left scaled sample, signed |
| out_right | output | 16 | Right scaled sample, signed |

## Verification
If the ramp state machine or its offset is wrong, every later sample comes out at the wrong level. The fault therefore appears at the ports on the first output after the bad step, two cycles after the sample that caused it, and it persists until the offset returns to zero. The bench drives long fades in both directions, with reversals part-way through, and compares each sample against a model of the offset. This locates a missed, doubled or misplaced step to the exact sample. To expose a design that reads the controls outside the sample cycle, the bench puts misleading codes, mute and bypass values on the inputs in the idle cycles between samples. Any such leak then appears in the next output.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int FRAC_W    = 14;
    localparam int OCT_STEPS = 12;
    localparam int MANT_W    = FRAC_W + 1;

    typedef enum logic [1:0] {
        MS_PASS = 2'd0,
        MS_FALL = 2'd1,
        MS_HELD = 2'd2,
        MS_RISE = 2'd3
    } mute_state_t;

    typedef struct packed {
        logic       silent;
        logic [5:0] shamt;
        logic [3:0] step;
    } level_t;

    // 2^(step/12) in Q14, rounded to nearest
    function automatic logic [MANT_W-1:0] mantissa(input logic [3:0] step);
        logic [MANT_W-1:0] m;
        unique case (step)
            4'd0:    m = 15'd16384;
            4'd1:    m = 15'd17358;
            4'd2:    m = 15'd18390;
            4'd3:    m = 15'd19484;
            4'd4:    m = 15'd20643;
            4'd5:    m = 15'd21870;
            4'd6:    m = 15'd23170;
            4'd7:    m = 15'd24548;
            4'd8:    m = 15'd26008;
            4'd9:    m = 15'd27554;
            4'd10:   m = 15'd29193;
            4'd11:   m = 15'd30929;
            default: m = 15'd16384;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vol_mute_fsm.sv
module vol_mute_fsm
    import vol_pkg::*;
#(
    parameter int STEPS = 256,
    parameter int OFS_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             mute_req,
    output mute_state_t      state_q,
    output logic [OFS_W-1:0] ofs_q,
    output logic [OFS_W-1:0] ofs_nxt
);

    localparam logic [OFS_W-1:0] OFS_ONE  = OFS_W'(1);
    localparam logic [OFS_W-1:0] OFS_TOP  = OFS_W'(STEPS - 1);
    localparam logic [OFS_W-1:0] OFS_NEAR = OFS_W'(STEPS - 2);

    mute_state_t state_nxt;

    // next-state and next-offset logic
    always_comb begin
        state_nxt = state_q;
        ofs_nxt   = ofs_q;
        if (step_en) begin
            unique case (state_q)
                MS_PASS: begin
                    if (mute_req) begin                      // start_fade
                        ofs_nxt   = OFS_ONE;
                        state_nxt = (OFS_ONE == OFS_TOP) ? MS_HELD : MS_FALL;
                    end
                end
                MS_FALL: begin
                    if (mute_req) begin
                        ofs_nxt = ofs_q + OFS_ONE;
                        if (ofs_q == OFS_NEAR) state_nxt = MS_HELD;   // reach_floor
                    end else begin
                        ofs_nxt   = ofs_q - OFS_ONE;
                        state_nxt = (ofs_q == OFS_ONE) ? MS_PASS : MS_RISE; // settle / release
                    end
                end
                MS_HELD: begin
                    if (!mute_req) begin                     // release
                        ofs_nxt   = ofs_q - OFS_ONE;
                        state_nxt = (ofs_q == OFS_ONE) ? MS_PASS : MS_RISE;
                    end
                end
                MS_RISE: begin
                    if (mute_req) begin                      // resume_fade
                        ofs_nxt   = ofs_q + OFS_ONE;
                        state_nxt = (ofs_q == OFS_NEAR) ? MS_HELD : MS_FALL;
                    end else begin
                        ofs_nxt = ofs_q - OFS_ONE;
                        if (ofs_q == OFS_ONE) state_nxt = MS_PASS;    // settle
                    end
                end
                default: begin
                    state_nxt = MS_PASS;
                    ofs_nxt   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_PASS;
            ofs_q   <= '0;
        end else begin
            state_q <= state_nxt;
            ofs_q   <= ofs_nxt;
        end
    end

endmodule

// File: rtl/vol_level_calc.sv
module vol_level_calc
    import vol_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int GAIN_TOP = 48,
    parameter int OFS_W    = 8
) (
    input  logic signed [CODE_W-1:0] code,
    input  logic        [OFS_W-1:0]  ofs,
    input  logic                     bypass,
    output level_t                   level
);

    localparam int EW         = CODE_W + OFS_W + 2;
    localparam int FLOOR_CODE = -(2 ** (CODE_W - 1)) + 1;
    localparam int BIAS_OCT   = (-FLOOR_CODE + OCT_STEPS - 1) / OCT_STEPS;
    localparam int BIAS       = BIAS_OCT * OCT_STEPS;
    localparam int SH_BASE    = BIAS_OCT + FRAC_W;

    localparam logic signed [EW-1:0]     TOP_X   = EW'(GAIN_TOP);
    localparam logic signed [EW-1:0]     FLOOR_X = EW'(FLOOR_CODE);
    localparam logic signed [EW-1:0]     BIAS_X  = EW'(BIAS);
    localparam logic signed [CODE_W-1:0] MUTE_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic signed [EW-1:0] code_x, clamped, ofs_x, eff, biased;
    logic        [EW-1:0] ub, qv, rv;

    always_comb begin
        code_x = {{(EW-CODE_W){code[CODE_W-1]}}, code};
        ofs_x  = {{(EW-OFS_W){1'b0}}, ofs};
        if (bypass)
            clamped = '0;
        else if (code_x > TOP_X)
            clamped = TOP_X;
        else
            clamped = code_x;
        eff    = clamped - ofs_x;
        biased = eff + BIAS_X;
        ub     = biased;
        qv     = ub / EW'(OCT_STEPS);
        rv     = ub % EW'(OCT_STEPS);
        level.silent = (!bypass && code == MUTE_CODE) || (eff < FLOOR_X);
        if (level.silent) begin
            level.shamt = '0;
            level.step  = '0;
        end else begin
            level.shamt = 6'(EW'(SH_BASE) - qv);
            level.step  = rv[3:0];
        end
    end

endmodule

// File: rtl/vol_scaler.sv
module vol_scaler
    import vol_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  level_t                     level,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam int PW = SAMPLE_W + MANT_W + 2;
    localparam logic signed [PW-1:0] MAX_X = PW'(2 ** (SAMPLE_W - 1) - 1);
    localparam logic signed [PW-1:0] MIN_X = -PW'(2 ** (SAMPLE_W - 1));

    logic signed [PW-1:0]       smp_x, mant_x, prod, shifted;
    logic signed [SAMPLE_W-1:0] clipped;

    always_comb begin
        smp_x   = {{(PW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
        mant_x  = {{(PW-MANT_W){1'b0}}, mantissa(level.step)};
        prod    = smp_x * mant_x;
        shifted = prod >>> level.shamt;
        if (shifted > MAX_X)
            clipped = MAX_X[SAMPLE_W-1:0];
        else if (shifted < MIN_X)
            clipped = MIN_X[SAMPLE_W-1:0];
        else
            clipped = shifted[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result <= '0;
        else if (en)
            result <= level.silent ? '0 : clipped;
    end

endmodule

// File: rtl/soft_mute_volume.sv
module soft_mute_volume
    import vol_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int CODE_W     = 8,
    parameter int GAIN_TOP   = 48,
    parameter int MUTE_STEPS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic signed [CODE_W-1:0]   vol_left,
    input  logic signed [CODE_W-1:0]   vol_right,
    input  logic                       mute_req,
    input  logic                       agc_bypass,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);

    localparam int OFS_W = $clog2(MUTE_STEPS);
    localparam int NCH   = 2;

    mute_state_t      mute_state;
    logic [OFS_W-1:0] mute_ofs;
    logic [OFS_W-1:0] ofs_step;
    logic             s1_valid;

    logic signed [SAMPLE_W-1:0] smp_in  [NCH];
    logic signed [CODE_W-1:0]   code_in [NCH];
    logic signed [SAMPLE_W-1:0] smp_q   [NCH];
    logic signed [SAMPLE_W-1:0] smp_out [NCH];
    level_t                     lvl_c   [NCH];
    level_t                     lvl_q   [NCH];

    assign smp_in[0]  = in_left;
    assign smp_in[1]  = in_right;
    assign code_in[0] = vol_left;
    assign code_in[1] = vol_right;

    vol_mute_fsm #(
        .STEPS (MUTE_STEPS),
        .OFS_W (OFS_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (in_valid),
        .mute_req (mute_req),
        .state_q  (mute_state),
        .ofs_q    (mute_ofs),
        .ofs_nxt  (ofs_step)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        vol_level_calc #(
            .CODE_W   (CODE_W),
            .GAIN_TOP (GAIN_TOP),
            .OFS_W    (OFS_W)
        ) u_lvl (
            .code   (code_in[ch]),
            .ofs    (ofs_step),
            .bypass (agc_bypass),
            .level  (lvl_c[ch])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[ch] <= '0;
                lvl_q[ch] <= '0;
            end else if (in_valid) begin
                smp_q[ch] <= smp_in[ch];
                lvl_q[ch] <= lvl_c[ch];
            end
        end

        vol_scaler #(
            .SAMPLE_W (SAMPLE_W)
        ) u_scl (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (s1_valid),
            .sample (smp_q[ch]),
            .level  (lvl_q[ch]),
            .result (smp_out[ch])
        );
    end

    // output strobe pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];

endmodule

module soft_mute_volume_chk
    import vol_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 8,
    parameter int OFS_W    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_left,
    input logic signed [SAMPLE_W-1:0] in_right,
    input logic signed [CODE_W-1:0]   vol_left,
    input logic signed [CODE_W-1:0]   vol_right,
    input logic                       mute_req,
    input logic                       agc_bypass,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_left,
    input logic signed [SAMPLE_W-1:0] out_right,
    input mute_state_t                mute_state,
    input logic [OFS_W-1:0]           mute_ofs
);

    localparam logic signed [CODE_W-1:0] MUTE_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);                                      // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);                                    // R10
    AST_FULL_MUTE_L: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && !$past(agc_bypass, 2)
         && $past(vol_left, 2) == MUTE_CODE) |-> out_left == '0);         // R4
    AST_FULL_MUTE_R: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && !$past(agc_bypass, 2)
         && $past(vol_right, 2) == MUTE_CODE) |-> out_right == '0);       // R4
    AST_BYPASS_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(agc_bypass, 2)
         && $past(mute_state, 1) == MS_PASS)
        |-> (out_left == $past(in_left, 2) && out_right == $past(in_right, 2))); // R9
    AST_FADE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_req) |=> mute_ofs >= $past(mute_ofs));          // R7
    AST_FADE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute_req) |=> mute_ofs <= $past(mute_ofs));         // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(mute_ofs));                                 // R6

endmodule

bind soft_mute_volume soft_mute_volume_chk #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W),
    .OFS_W    (OFS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_left    (in_left),
    .in_right   (in_right),
    .vol_left   (vol_left),
    .vol_right  (vol_right),
    .mute_req   (mute_req),
    .agc_bypass (agc_bypass),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right),
    .mute_state (mute_state),
    .mute_ofs   (mute_ofs)
);

// File: tb/tb_soft_mute_volume.sv
`timescale 1ns/1ps
module tb_soft_mute_volume;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_left = '0, in_right = '0;
    logic signed [7:0]  vol_left = '0, vol_right = '0;
    logic              mute_req = 1'b0, agc_bypass = 1'b0;
    logic              out_valid;
    logic signed [15:0] out_left, out_right;

    int checks = 0;
    int failures = 0;
    int model_ofs = 0;
    bit done = 1'b0;

    typedef struct {
        int    l;
        int    r;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    soft_mute_volume dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .vol_left(vol_left), .vol_right(vol_right),
        .mute_req(mute_req), .agc_bypass(agc_bypass),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic int model(int x, int code, int ofs, bit byp);
        int c, e, u, q, r, sh, m;
        longint p;
        if (!byp && code == -128) return 0;
        c = byp ? 0 : ((code > 48) ? 48 : code);
        e = c - ofs;
        if (e < -127) return 0;
        u  = e + 132;
        q  = u / 12;
        r  = u % 12;
        sh = 25 - q;
        m  = int'($floor(16384.0 * (2.0 ** (real'(r) / 12.0)) + 0.5));
        p  = longint'(x) * longint'(m);
        p  = p >>> sh;
        if (p > 32767) return 32767;
        if (p < -32768) return -32768;
        return int'(p);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // driver: one sample, then an idle cycle with misleading control values
    task automatic send(int l, int r, int vl, int vr, bit mute, bit byp, string tag);
        exp_t it;
        @(negedge clk);
        in_valid   = 1'b1;
        in_left    = 16'(l);
        in_right   = 16'(r);
        vol_left   = 8'(vl);
        vol_right  = 8'(vr);
        mute_req   = mute;
        agc_bypass = byp;
        if (mute && model_ofs < 255) model_ofs++;
        else if (!mute && model_ofs > 0) model_ofs--;
        it.l   = model(l, vl, model_ofs, byp);
        it.r   = model(r, vr, model_ofs, byp);
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        in_valid   = 1'b0;
        vol_left   = -8'sd128;   // R6: ignored outside the sample cycle
        vol_right  = 8'sd77;
        mute_req   = ~mute;
        agc_bypass = ~byp;
        in_left    = 16'h7fff;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected out_valid", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(int'(out_left) == it.l, it.tag, "left", int'(out_left), it.l);
                check(int'(out_right) == it.r, it.tag, "right", int'(out_right), it.r);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "WATCHDOG", "run timed out", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        check(out_left == 0, "R11", "out_left after reset", int'(out_left), 0);
        check(out_right == 0, "R11", "out_right after reset", int'(out_right), 0);

        // R1 unity at code 0 (also confirms zero offset after reset, R11)
        send(1234, -1234, 0, 0, 0, 0, "R1");
        send(-32768, 32767, 0, 0, 0, 0, "R1");
        send(0, 1, 0, 0, 0, 0, "R11");

        // R2 boost, clamp and saturation
        send(1000, -1000, 12, 12, 0, 0, "R2");
        send(1000, -1000, 48, 48, 0, 0, "R2");
        send(1000, -1000, 100, 127, 0, 0, "R2");
        send(20000, -20000, 12, 48, 0, 0, "R2");

        // R3 attenuation across the range
        send(30000, -30000, -1, -6, 0, 0, "R3");
        send(30000, -30000, -20, -61, 0, 0, "R3");
        send(30000, -7, -127, -127, 0, 0, "R3");
        send(12345, 23456, 7, 31, 0, 0, "R3");

        // R4 full mute code
        send(30000, 30000, -128, 0, 0, 0, "R4");
        send(-5000, 5000, 0, -128, 0, 0, "R4");

        // R5 independent channels
        send(8000, 8000, 24, -24, 0, 0, "R5");
        send(-8000, 100, -60, 40, 0, 0, "R5");

        // R6 idle-cycle garbage is already applied between every sample
        send(4321, -4321, 0, 0, 0, 0, "R6");

        // R7 fade down to full attenuation and hold
        for (int i = 0; i < 270; i++) send(12000, -9000, 0, 6, 1, 0, "R7");
        // R8 partial release, reversal, full release
        for (int i = 0; i < 30; i++) send(12000, -9000, 0, 6, 0, 0, "R8");
        for (int i = 0; i < 10; i++) send(12000, -9000, 0, 6, 1, 0, "R7");
        for (int i = 0; i < 260; i++) send(12000, -9000, 0, 6, 0, 0, "R8");
        send(12000, -9000, 0, 6, 0, 0, "R8");

        // R9 bypass: codes ignored, mute offset still applied
        send(7777, -7777, -128, 48, 0, 1, "R9");
        send(7777, -7777, -60, 100, 0, 1, "R9");
        for (int i = 0; i < 8; i++) send(7777, -7777, -128, 20, 1, 1, "R9");
        for (int i = 0; i < 8; i++) send(7777, -7777, -128, 20, 0, 1, "R9");
        send(7777, -7777, -128, 20, 0, 1, "R9");

        // back-to-back samples (R10)
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            exp_t it;
            in_valid  = 1'b1;
            in_left   = 16'(100 * i);
            in_right  = 16'(-100 * i);
            vol_left  = 8'sd0;
            vol_right = 8'sd12;
            mute_req  = 1'b0;
            agc_bypass = 1'b0;
            it.l = model(100 * i, 0, 0, 1'b0);
            it.r = model(-100 * i, 12, 0, 1'b0);
            it.tag = "R10";
            sb.push_back(it);
            @(negedge clk);
        end
        in_valid = 1'b0;

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R10", "missing outputs", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule